// File: doc/BRIEF.md
# Vertical Sync Detector with Timeout

This block watches a digitized, active-low composite sync stream that has been sampled on the system clock. It produces one active-low vertical sync pulse of fixed width per field. It times the low part of every sync pulse. Short lows are horizontal or equalizing pulses. Long lows are the broad pulses of the vertical serration phase. The vertical pulse begins on the trailing (rising) edge of the first broad pulse after the detector has been armed by a short pulse.

Some video has no serrations and holds sync low through the vertical interval. For that case a watchdog on the current low time forces the same pulse once the low has lasted longer than a default delay. After a pulse, the detector ignores every broad edge and every timeout. It stays that way until the pulse has ended and a short pulse has been seen again. All times are parameters counted in clock cycles. The input passes through a two-flop synchronizer before any edge is taken.

Top module: `vsync_detector`

## Requirements
- R1: While reset is asserted and after it is released, `vsync_n` is high. The detector starts disarmed, so a broad pulse that arrives before any narrow pulse produces no vertical pulse.
- R2: A low pulse lasting L cycles counts as broad when L > BROAD_MIN and as narrow when L <= BROAD_MIN. A pulse of exactly BROAD_MIN cycles never triggers. A pulse of BROAD_MIN+1 cycles triggers when the detector is armed.
- R3: When the detector is armed, the end of a broad pulse drives `vsync_n` low. Count the clock edge that first samples the input high as edge 1. `vsync_n` goes low at edge 3.
- R4: When the detector is armed and the input stays low for more than DEFAULT_DLY cycles, `vsync_n` goes low at edge DEFAULT_DLY+3, counting the edge that first samples the low as edge 1. A low of exactly DEFAULT_DLY cycles causes no timeout and triggers on its rising edge as in R3.
- R5: Every vertical pulse keeps `vsync_n` low for exactly VS_WIDTH cycles, whichever trigger started it.
- R6: While a vertical pulse is running, broad pulse ends and timeouts start no further pulse. This includes the broad edge that ends the same long low that timed out. The result is one pulse per field.
- R7: After a pulse, the detector re-arms only on a narrow pulse whose rising edge is first sampled at or after the clock edge at which `vsync_n` returns high. A narrow pulse whose rising edge is sampled one edge earlier does not re-arm it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| sync_n | input | 1 | Digitized composite sync, active low, asynchronous to clk |
| vsync_n | output | 1 | Vertical sync, active low, VS_WIDTH cycles wide |

## Verification
Two events can land in the same cycle: the one-shot expiring and a narrow pulse ending, which is the event that arms the detector. The bench places the rising edge of an equalizing pulse so that it is first sampled exactly one edge before `vsync_n` returns high. It then sends a broad pulse and expects no vertical pulse. It then sends one more narrow pulse followed by a broad pulse and expects a vertical pulse on the exact predicted cycle. A second boundary pairs the timeout with the trailing edge of a long low, at lengths of DEFAULT_DLY and DEFAULT_DLY+1 cycles. Exactly one of the two triggers must fire in each case, on its own predicted cycle.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  typedef enum logic [1:0] {
    PH_WAIT_H = 2'd0,
    PH_ARMED  = 2'd1,
    PH_FIRED  = 2'd2
  } vsd_phase_e;
endpackage

// File: rtl/vsd_sync_in.sv
module vsd_sync_in #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic src;
    if (i == 0) begin : g_first
      assign src = sync_n_i;
    end else begin : g_next
      assign src = sh_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q[i] <= 1'b1;
      else        sh_q[i] <= src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sh_q[STAGES-1];
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/vsd_low_meter.sv
module vsd_low_meter #(
  parameter int CNT_W       = 12,
  parameter int BROAD_MIN   = 800,
  parameter int DEFAULT_DLY = 3100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic rise_i,
  output logic narrow_end_o,
  output logic broad_end_o,
  output logic timeout_o
);
  localparam logic [CNT_W-1:0] BROAD_C = CNT_W'(BROAD_MIN);
  localparam logic [CNT_W-1:0] DLY_C   = CNT_W'(DEFAULT_DLY);

  logic [CNT_W-1:0] low_q, low_d;
  logic             cnt_en;

  assign cnt_en = ~lvl_i && (low_q != '1);

  always_comb begin
    low_d = low_q;
    if (lvl_i)       low_d = '0;
    else if (cnt_en) low_d = low_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= '0;
    else        low_q <= low_d;
  end

  assign narrow_end_o = rise_i && (low_q <= BROAD_C);
  assign broad_end_o  = rise_i && (low_q >  BROAD_C);
  assign timeout_o    = ~lvl_i && (low_q == DLY_C);

  // R4: the timeout is a single-cycle event for each long low
  a_r4_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
  // R4: a timeout only happens while the line has been low on the previous cycle too
  a_r4_timeout_low: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> $past(!lvl_i));
endmodule

// File: rtl/vsd_phase_ctrl.sv
module vsd_phase_ctrl
  import vsd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic narrow_end_i,
  input  logic broad_end_i,
  input  logic timeout_i,
  input  logic busy_i,
  output logic fire_o
);
  vsd_phase_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PH_WAIT_H: if (narrow_end_i)              st_d = PH_ARMED;
      PH_ARMED:  if (broad_end_i || timeout_i)  st_d = PH_FIRED;
      PH_FIRED:  if (!busy_i)                   st_d = PH_WAIT_H;
      default:                                  st_d = PH_WAIT_H;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PH_WAIT_H;
    else        st_q <= st_d;
  end

  assign fire_o = (st_q == PH_ARMED) && (broad_end_i || timeout_i);

  // R7: the detector can never jump from waiting straight to firing
  a_r7_no_skip_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_WAIT_H) |=> (st_q != PH_FIRED));
  // R6: once fired, the one-shot is running on the next cycle
  a_r6_fired_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> busy_i);
endmodule

// File: rtl/vsd_oneshot.sv
module vsd_oneshot #(
  parameter int VS_WIDTH = 11500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o,
  output logic vs_n_o
);
  localparam int W_W = $clog2(VS_WIDTH + 1);
  localparam logic [W_W-1:0] WIDTH_C = W_W'(VS_WIDTH);

  logic [W_W-1:0] cnt_q, cnt_d;
  logic           dec_en;

  assign dec_en = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = WIDTH_C;
    else if (dec_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = dec_en;
  assign vs_n_o = ~dec_en;

  // R5: a running pulse counts down by exactly one each cycle
  a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/vsync_detector.sv
module vsync_detector #(
  parameter int BROAD_MIN   = 800,
  parameter int DEFAULT_DLY = 3100,
  parameter int VS_WIDTH    = 11500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  output logic vsync_n
);
  localparam int MAX_LOW = (DEFAULT_DLY > BROAD_MIN) ? DEFAULT_DLY : BROAD_MIN;
  localparam int CNT_W   = $clog2(MAX_LOW + 2);

  logic lvl, rise, narrow_end, broad_end, timeout, busy, fire;

  vsd_sync_in #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sync_n_i(sync_n), .lvl_o(lvl), .rise_o(rise)
  );

  vsd_low_meter #(.CNT_W(CNT_W), .BROAD_MIN(BROAD_MIN), .DEFAULT_DLY(DEFAULT_DLY)) u_meter (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .rise_i(rise),
    .narrow_end_o(narrow_end), .broad_end_o(broad_end), .timeout_o(timeout)
  );

  vsd_phase_ctrl u_phase (
    .clk(clk), .rst_n(rst_n), .narrow_end_i(narrow_end), .broad_end_i(broad_end),
    .timeout_i(timeout), .busy_i(busy), .fire_o(fire)
  );

  vsd_oneshot #(.VS_WIDTH(VS_WIDTH)) u_shot (
    .clk(clk), .rst_n(rst_n), .load_i(fire), .busy_o(busy), .vs_n_o(vsync_n)
  );

  // R6: no trigger is issued while a pulse is still running
  a_r6_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fire);
  // R3: a trigger pulls the output low on the next cycle
  a_r3_fire_drops: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !vsync_n);
endmodule

// File: tb/vsync_detector_tb_top.sv
module vsync_detector_tb_top;
  localparam int BROAD = 40;
  localparam int DLY   = 300;
  localparam int W     = 600;
  localparam int K_NONE = 0, K_EDGE = 1, K_TMO = 2;

  logic clk = 1'b0, rst_n = 1'b0, sync_n = 1'b1;
  logic vsync_n;
  int cyc = 0, checks = 0, errors = 0, seen = 0, pushed = 0, fall_cyc = 0;
  bit prev_vs = 1'b1, done = 1'b0;
  int qc[$];
  string qt[$];

  vsync_detector #(.BROAD_MIN(BROAD), .DEFAULT_DLY(DLY), .VS_WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .vsync_n(vsync_n)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(int c, string tag);
    qc.push_back(c); qt.push_back(tag); pushed++;
  endtask

  // one sync pulse: L cycles low then H cycles high; entered at a negedge
  task automatic pulse(int L, int H, int kind, string tag);
    sync_n = 1'b0;
    if (kind == K_TMO) push(cyc + DLY + 3, tag);
    repeat (L) @(negedge clk);
    sync_n = 1'b1;
    if (kind == K_EDGE) push(cyc + 3, tag);
    repeat (H) @(negedge clk);
  endtask

  task automatic lines(int n);
    for (int i = 0; i < n; i++) pulse(15, 185, K_NONE, "");
  endtask

  task automatic eqs(int n);
    for (int i = 0; i < n; i++) pulse(7, 93, K_NONE, "");
  endtask

  task automatic quiet(string tag);
    chk(seen == pushed, tag, seen, pushed);
  endtask

  // monitor: pops expected fall cycles and checks pulse width
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_vs && !vsync_n) begin
        seen++;
        if (qc.size() == 0) chk(1'b0, "R6", cyc, -1);
        else begin
          int e;
          string t;
          e = qc.pop_front(); t = qt.pop_front();
          chk(cyc == e, t, cyc, e);
        end
        fall_cyc = cyc;
      end
      if (!prev_vs && vsync_n) chk(cyc - fall_cyc == W, "R5", cyc - fall_cyc, W);
      prev_vs = vsync_n;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk(vsync_n == 1'b1, "R1", vsync_n, 1);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vsync_n == 1'b1, "R1", vsync_n, 1);
    // R1: broad pulse before any narrow pulse is ignored
    pulse(85, 15, K_NONE, "");
    repeat (20) @(negedge clk);
    quiet("R1");
    // R3, R6: standard field with serrations
    lines(3); eqs(6);
    pulse(85, 15, K_EDGE, "R3");
    for (int i = 0; i < 5; i++) pulse(85, 15, K_NONE, "");
    eqs(6); lines(3);
    quiet("R6");
    // R4, R6: field without serrations
    lines(3); eqs(6);
    pulse(500, 100, K_TMO, "R4");
    eqs(6); lines(3);
    quiet("R6");
    // R2: threshold boundary
    pulse(BROAD, 160, K_NONE, "");
    quiet("R2");
    pulse(BROAD + 1, 159, K_EDGE, "R2");
    lines(4);
    // R4: timeout boundary
    pulse(DLY, 100, K_EDGE, "R4");
    lines(4);
    pulse(DLY + 1, 100, K_TMO, "R4");
    lines(4);
    quiet("R4");
    // R7: narrow edge sampled one edge before the pulse ends does not re-arm
    pulse(85, W - 6, K_EDGE, "R3");
    pulse(7, 100, K_NONE, "");
    pulse(85, 15, K_NONE, "");
    quiet("R7");
    pulse(7, 93, K_NONE, "");
    pulse(85, 15, K_EDGE, "R7");
    lines(4);
    quiet("R7");
    chk(qc.size() == 0, "R7", qc.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule